// File: doc/BRIEF.md
# Packet-Hold Request Arbiter

This block chooses one requester out of a parameterized set and keeps that choice until the chosen requester reports that it is finished. It is meant to sit in front of a shared resource that carries whole packets. The surrounding logic raises the finished bit for the granted port when the last beat of that port's packet completes its valid/ready handshake. A packet therefore crosses the shared resource without being interleaved with another.

Two elaboration-time parameters set the selection rule. The policy parameter picks either a strict fixed order or a rotating order. The tie parameter decides whether lower or higher indices come first. The grant is published three ways: as a one-hot vector, as a valid flag, and as a binary index. All grant changes are registered, and reset is synchronous.

Top module: `arb_pkt_hold`

## Requirements
- R1: While `rst` is high at a clock edge, the edge leaves `grant` all zeros, `grant_valid` low and `grant_idx` zero. In rotating mode it also sets the search start to port 0 when lower indices come first, or to port PORTS-1 when higher indices come first. So the first grant after reset with every port requesting goes to port 0 or to port PORTS-1.
- R2: `grant` never has more than one bit set, and `grant_valid` is high exactly when one bit of `grant` is set.
- R3: When nothing is granted and `req` is all zeros at an edge, the outputs after that edge show no grant and `grant_idx` equal to zero.
- R4: While a port holds the grant and its own `ack` bit is low at an edge, the grant stays unchanged across that edge, whatever `req` carries. This includes the holder dropping its own request and higher-ranked ports requesting.
- R5: `ack` bits of ports that do not hold the grant have no effect.
- R6: When the holder's `ack` bit is high at an edge, that edge clears the grant. At least one cycle with no grant therefore separates two grants. A request present in that idle cycle is granted at the following edge.
- R7: In fixed mode (policy `ARB_POL_FIXED`), an edge that finds no grant and at least one request grants the lowest requesting index when the tie setting is `ARB_TIE_LOW`, or the highest requesting index when it is `ARB_TIE_HIGH`.
- R8: In rotating mode (policy `ARB_POL_ROTATE`), releasing port p moves the search start to the next index after p. With `ARB_TIE_LOW` that is p+1, wrapping from PORTS-1 to 0. With `ARB_TIE_HIGH` it is p-1, wrapping from 0 to PORTS-1. The next grant goes to the first requesting port met when walking from the search start in that direction.
- R9: Grants change only at a rising clock edge. A new grant is issued only from the no-grant state, and only to a port whose `req` bit was high at that edge.
- R10: `grant_idx` is the plain binary position, clog2(PORTS) bits wide, of the set bit of `grant` whenever `grant_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | PORTS | Request bit per port |
| ack | input | PORTS | Finished strobe per port; only the holder's bit counts |
| grant | output | PORTS | One-hot grant vector |
| grant_valid | output | 1 | High while some port holds the grant |
| grant_idx | output | clog2(PORTS) | Binary index of the granted port, zero when idle |

## Verification
Four instances cover every policy and tie combination, and all four receive the same stimulus. With every port requesting at once, the instances must differ in their first grant and again after one release. That separates the reset search start, the tie direction and the pointer advance. Pulses on non-holder finished bits, and requests dropped or raised while a grant is held, distinguish true packet holding from re-arbitration. A long random phase with sparse finished strobes exercises wrap-around of the rotating pointer and the idle cycle that follows every release.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // Selection rule applied whenever no port holds the grant.
   typedef enum logic {
      ARB_POL_FIXED  = 1'b0,
      ARB_POL_ROTATE = 1'b1
   } arb_policy_e;

   // Which end of the index range is searched first.
   typedef enum logic {
      ARB_TIE_LOW  = 1'b0,
      ARB_TIE_HIGH = 1'b1
   } arb_tie_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/arb_first_pick.sv
// Finds the first set bit of a candidate vector, searching from the
// end chosen by TIE. Purely combinational.
module arb_first_pick #(
   parameter int unsigned       N    = 4,
   parameter arb_pkg::arb_tie_e TIE  = arb_pkg::ARB_TIE_LOW,
   localparam int unsigned      IW   = arb_pkg::idx_width(N)
) (
   input  logic [N-1:0]  cand,
   output logic [N-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          any
);

   assign any = |cand;

   generate
      if (TIE == arb_pkg::ARB_TIE_LOW) begin : g_low_first
         // Walk downward so that the lowest set bit is written last.
         always_comb begin
            onehot = '0;
            idx    = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (cand[i]) begin
                  onehot    = '0;
                  onehot[i] = 1'b1;
                  idx       = IW'(i);
               end
            end
         end
      end else begin : g_high_first
         // Walk upward so that the highest set bit is written last.
         always_comb begin
            onehot = '0;
            idx    = '0;
            for (int i = 0; i < N; i++) begin
               if (cand[i]) begin
                  onehot    = '0;
                  onehot[i] = 1'b1;
                  idx       = IW'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/arb_rr_window.sv
// Rotating search start. Holds a pointer and produces a mask of the
// ports that lie at or beyond the pointer in the search direction.
module arb_rr_window #(
   parameter int unsigned       N   = 4,
   parameter arb_pkg::arb_tie_e TIE = arb_pkg::ARB_TIE_LOW,
   localparam int unsigned      IW  = arb_pkg::idx_width(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          advance,
   input  logic [IW-1:0] from_idx,
   output logic [N-1:0]  window
);

   localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);
   localparam logic [IW-1:0] HOME_IDX = (TIE == arb_pkg::ARB_TIE_LOW) ? '0 : LAST_IDX;

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] ptr_next;

   generate
      if (TIE == arb_pkg::ARB_TIE_LOW) begin : g_step_up
         always_comb begin
            ptr_next = (from_idx == LAST_IDX) ? '0 : from_idx + IW'(1);
         end
         for (genvar b = 0; b < N; b++) begin : g_win
            assign window[b] = (IW'(b) >= ptr_q);
         end
      end else begin : g_step_down
         always_comb begin
            ptr_next = (from_idx == '0) ? LAST_IDX : from_idx - IW'(1);
         end
         for (genvar b = 0; b < N; b++) begin : g_win
            assign window[b] = (IW'(b) <= ptr_q);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= HOME_IDX;
      end else if (advance) begin
         ptr_q <= ptr_next;
      end
   end

endmodule

// File: rtl/arb_pkt_hold.sv
// Packet-hold arbiter: grants one requester and keeps the grant until
// the holder raises its ack bit.
module arb_pkt_hold #(
   parameter int unsigned          PORTS  = 4,
   parameter arb_pkg::arb_policy_e POLICY = arb_pkg::ARB_POL_ROTATE,
   parameter arb_pkg::arb_tie_e    TIE    = arb_pkg::ARB_TIE_LOW,
   localparam int unsigned         IDX_W  = arb_pkg::idx_width(PORTS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PORTS-1:0] req,
   input  logic [PORTS-1:0] ack,
   output logic [PORTS-1:0] grant,
   output logic             grant_valid,
   output logic [IDX_W-1:0] grant_idx
);

   generate
      if (PORTS < 2) begin : g_bad_ports
         $error("arb_pkt_hold: PORTS must be at least 2");
      end
   endgenerate

   logic [PORTS-1:0] grant_q;
   logic             valid_q;
   logic [IDX_W-1:0] idx_q;

   logic             release_now;
   logic [PORTS-1:0] pick_oh;
   logic [IDX_W-1:0] pick_idx;
   logic             pick_any;

   // Only the holder's own ack bit can end a grant.
   assign release_now = valid_q && |(ack & grant_q);

   generate
      if (POLICY == arb_pkg::ARB_POL_ROTATE) begin : g_rotate
         logic [PORTS-1:0] window;
         logic [PORTS-1:0] near_oh;
         logic [IDX_W-1:0] near_idx;
         logic             near_any;
         logic [PORTS-1:0] wrap_oh;
         logic [IDX_W-1:0] wrap_idx;
         logic             wrap_any;

         arb_rr_window #(
            .N   (PORTS),
            .TIE (TIE)
         ) u_window (
            .clk      (clk),
            .rst      (rst),
            .advance  (release_now),
            .from_idx (idx_q),
            .window   (window)
         );

         // Requests from the pointer onward take precedence.
         arb_first_pick #(
            .N   (PORTS),
            .TIE (TIE)
         ) u_pick_near (
            .cand   (req & window),
            .onehot (near_oh),
            .idx    (near_idx),
            .any    (near_any)
         );

         // Otherwise the search wraps to the start of the range.
         arb_first_pick #(
            .N   (PORTS),
            .TIE (TIE)
         ) u_pick_wrap (
            .cand   (req),
            .onehot (wrap_oh),
            .idx    (wrap_idx),
            .any    (wrap_any)
         );

         assign pick_oh  = near_any ? near_oh  : wrap_oh;
         assign pick_idx = near_any ? near_idx : wrap_idx;
         assign pick_any = wrap_any;
      end else begin : g_fixed
         arb_first_pick #(
            .N   (PORTS),
            .TIE (TIE)
         ) u_pick (
            .cand   (req),
            .onehot (pick_oh),
            .idx    (pick_idx),
            .any    (pick_any)
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_q <= '0;
         valid_q <= 1'b0;
         idx_q   <= '0;
      end else if (valid_q) begin
         if (release_now) begin
            grant_q <= '0;
            valid_q <= 1'b0;
            idx_q   <= '0;
         end
      end else if (pick_any) begin
         grant_q <= pick_oh;
         valid_q <= 1'b1;
         idx_q   <= pick_idx;
      end
   end

   assign grant       = grant_q;
   assign grant_valid = valid_q;
   assign grant_idx   = idx_q;

endmodule

// File: rtl/arb_pkt_hold_chk.sv
// Property checker attached to every arb_pkt_hold instance.
module arb_pkt_hold_chk #(
   parameter int unsigned  PORTS = 4,
   localparam int unsigned IDX_W = arb_pkg::idx_width(PORTS)
) (
   input logic             clk,
   input logic             rst,
   input logic [PORTS-1:0] req,
   input logic [PORTS-1:0] ack,
   input logic [PORTS-1:0] grant,
   input logic             grant_valid,
   input logic [IDX_W-1:0] grant_idx
);

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (grant == '0 && !grant_valid && grant_idx == '0));

   p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));

   p_valid_match_r2: assert property (@(posedge clk) disable iff (rst)
      grant_valid == ($countones(grant) == 1));

   p_idle_idx_r3: assert property (@(posedge clk) disable iff (rst)
      !grant_valid |-> grant_idx == '0);

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (grant_valid && !(|(ack & grant))) |=> (grant_valid && $stable(grant)));

   p_release_r6: assert property (@(posedge clk) disable iff (rst)
      (grant_valid && |(ack & grant)) |=> !grant_valid);

   p_new_from_req_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(grant_valid) |-> |($past(req) & grant));

   p_idx_pos_r10: assert property (@(posedge clk) disable iff (rst)
      grant_valid |-> grant[grant_idx]);

endmodule

bind arb_pkt_hold arb_pkt_hold_chk #(
   .PORTS (PORTS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req         (req),
   .ack         (ack),
   .grant       (grant),
   .grant_valid (grant_valid),
   .grant_idx   (grant_idx)
);

// File: tb/arb_pkt_hold_tb.sv
module arb_pkt_hold_tb;
   import arb_pkg::*;

   localparam int N  = 4;
   localparam int IW = 2;
   localparam int NC = 4;   // c0 rotate/low, c1 rotate/high, c2 fixed/low, c3 fixed/high

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] req = '0;
   logic [N-1:0] ack = '0;

   logic [N-1:0]  g  [NC];
   logic          v  [NC];
   logic [IW-1:0] ix [NC];

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   // Reference state per configuration.
   int m_idx [NC];
   int m_val [NC];
   int m_ptr [NC];

   always #10 clk = ~clk;   // 50 MHz

   arb_pkt_hold #(.PORTS(N), .POLICY(ARB_POL_ROTATE), .TIE(ARB_TIE_LOW)) u_dut (
      .clk(clk), .rst(rst), .req(req), .ack(ack),
      .grant(g[0]), .grant_valid(v[0]), .grant_idx(ix[0]));
   arb_pkt_hold #(.PORTS(N), .POLICY(ARB_POL_ROTATE), .TIE(ARB_TIE_HIGH)) u_dut_rh (
      .clk(clk), .rst(rst), .req(req), .ack(ack),
      .grant(g[1]), .grant_valid(v[1]), .grant_idx(ix[1]));
   arb_pkt_hold #(.PORTS(N), .POLICY(ARB_POL_FIXED), .TIE(ARB_TIE_LOW)) u_dut_fl (
      .clk(clk), .rst(rst), .req(req), .ack(ack),
      .grant(g[2]), .grant_valid(v[2]), .grant_idx(ix[2]));
   arb_pkt_hold #(.PORTS(N), .POLICY(ARB_POL_FIXED), .TIE(ARB_TIE_HIGH)) u_dut_fh (
      .clk(clk), .rst(rst), .req(req), .ack(ack),
      .grant(g[3]), .grant_valid(v[3]), .grant_idx(ix[3]));

   function automatic int model_pick(int c, logic [N-1:0] r);
      for (int k = 0; k < N; k++) begin
         int pos;
         case (c)
            0: pos = (m_ptr[c] + k) % N;
            1: pos = (m_ptr[c] - k + N) % N;
            2: pos = k;
            default: pos = N - 1 - k;
         endcase
         if (r[pos]) return pos;
      end
      return -1;
   endfunction

   task automatic model_edge(logic r_in, logic [N-1:0] q, logic [N-1:0] a);
      for (int c = 0; c < NC; c++) begin
         if (r_in) begin
            m_val[c] = 0;
            m_idx[c] = 0;
            m_ptr[c] = (c == 1) ? N - 1 : 0;
         end else if (m_val[c] != 0) begin
            if (a[m_idx[c]]) begin
               if (c == 0) m_ptr[c] = (m_idx[c] + 1) % N;
               if (c == 1) m_ptr[c] = (m_idx[c] + N - 1) % N;
               m_val[c] = 0;
               m_idx[c] = 0;
            end
         end else begin
            int p;
            p = model_pick(c, q);
            if (p >= 0) begin
               m_val[c] = 1;
               m_idx[c] = p;
            end
         end
      end
   endtask

   // Compare every instance with the model (R4 R6 R7 R8 R9) and check
   // the encoding independently (R2 R10).
   task automatic compare_all();
      for (int c = 0; c < NC; c++) begin
         logic [N-1:0] eg;
         int pos;
         int ones;
         eg = (m_val[c] != 0) ? (N'(1) << m_idx[c]) : '0;
         total++;
         if (g[c] !== eg || v[c] !== (m_val[c] != 0) || ix[c] !== IW'(m_idx[c])) begin
            bad++;
            $display("FAIL R4 R6 R7 R8 R9 cfg%0d: actual g=%b v=%b i=%0d expected g=%b v=%0d i=%0d",
                     c, g[c], v[c], ix[c], eg, m_val[c], m_idx[c]);
         end
         ones = 0;
         pos = 0;
         for (int b = 0; b < N; b++) if (g[c][b]) begin ones++; pos = b; end
         total++;
         if (ones > 1 || v[c] !== (ones == 1) || (ones == 1 && ix[c] !== IW'(pos))) begin
            bad++;
            $display("FAIL R2 R10 cfg%0d: actual g=%b v=%b i=%0d expected one-hot match i=%0d",
                     c, g[c], v[c], ix[c], pos);
         end
      end
   endtask

   task automatic step(logic [N-1:0] q, logic [N-1:0] a);
      logic r_now;
      req = q;
      ack = a;
      r_now = rst;
      @(posedge clk);
      model_edge(r_now, q, a);
      @(negedge clk);
      compare_all();
   endtask

   task automatic expect_grants(string tag, int e0, int e1, int e2, int e3);
      int e [NC];
      e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
      for (int c = 0; c < NC; c++) begin
         logic [N-1:0] eg;
         eg = (e[c] < 0) ? '0 : (N'(1) << e[c]);
         total++;
         if (g[c] !== eg || v[c] !== (e[c] >= 0)) begin
            bad++;
            $display("FAIL %s cfg%0d: actual g=%b v=%b expected g=%b", tag, c, g[c], v[c], eg);
         end
      end
   endtask

   initial begin
      @(negedge clk);
      // R1: held in reset
      step('1, '1);
      step('1, '0);
      step('0, '0);
      rst = 1'b0;
      expect_grants("R1 reset", -1, -1, -1, -1);
      step('0, '0);
      expect_grants("R3 idle", -1, -1, -1, -1);
      step(4'hF, '0);
      expect_grants("R1 R7 first grant", 0, 3, 0, 3);
      step(4'hF, 4'b0110);
      expect_grants("R5 foreign ack", 0, 3, 0, 3);
      step(4'h0, 4'b0110);
      expect_grants("R4 holder dropped req", 0, 3, 0, 3);
      step(4'hF, 4'b1001);
      expect_grants("R6 release", -1, -1, -1, -1);
      step(4'hF, '0);
      expect_grants("R7 R8 after release", 1, 2, 0, 3);
      step(4'b0001, '0);
      expect_grants("R4 others request", 1, 2, 0, 3);
      step(4'b1001, 4'hF);
      expect_grants("R6 release all", -1, -1, -1, -1);
      step(4'b1001, '0);
      expect_grants("R8 wrap", 3, 0, 0, 3);
      step('0, 4'hF);
      step('0, '0);
      expect_grants("R3 idle again", -1, -1, -1, -1);
      for (int t = 0; t < 4000; t++) begin
         logic [N-1:0] rq;
         logic [N-1:0] ak;
         rq = N'($urandom);
         ak = (($urandom % 3) == 0) ? N'($urandom) : '0;
         step(rq, ak);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog R9: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

endmodule